// File: doc/BRIEF.md
# Processor Trap Entry Unit

This block performs the state changes a processor makes when it takes a trap. It receives a single-cycle trap strobe with a 9-bit trap type and a snapshot of the current architectural registers. On that clock edge it commits four things: the new trap level, the new processor state flags, the adjusted register window pointer and the handler's PC and NPC. It also records the interrupted context in a per-level trap stack. That record holds the condition codes, address space identifier, masked state flags, window pointer, PC, NPC and trap type.

The trap level saturates in two steps. Below the next-to-last level it simply counts up. At the next-to-last level the reset/error flag is raised and the level counts up one final time. A trap taken at the limit is refused and a sticky error-state flag is raised. Traps fall into three classes, each selecting an alternate, MMU or interrupt global register set. Window spill, fill and clean-window traps each move the window pointer by their own amount, modulo the window count. The handler address takes the upper trap-base bits and a table-half bit chosen by the nesting depth, with the trap type placed in its slot. A combinational read port gives access to any trap stack entry.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, upd_valid and error_state are 0, upd_tl is 0 and every trap stack entry reads as zero.
- R2: A trap accepted with cur_tl below MAX_TL-1 yields upd_tl = cur_tl+1 and leaves state flag bit 5 (reset/error) as it was on cur_pstate.
- R3: A trap accepted with cur_tl equal to MAX_TL-1 sets state flag bit 5 and yields upd_tl = MAX_TL.
- R4: A trap with cur_tl at or above MAX_TL raises error_state (sticky until reset), produces no upd_valid and writes no trap stack entry.
- R5: The saved state word holds the condition codes in bits 39:32 and the ASI in bits 31:24. Bits 23:20 are zero, bits 19:8 hold the state flags after the bit-5 update masked with 0xF3F, and the low bits hold cur_cwp.
- R6: Each accepted trap writes the saved word, cur_pc, cur_npc and the trap type into the stack entry indexed by the new trap level.
- R7: Every accepted trap sets flag bits 4 (FPU enable) and 2 (privileged) and sets exactly one of bits 11, 10 and 0. Type 0x060 selects bit 11 (interrupt set). Types 0x008, 0x030, 0x064-0x067, 0x068-0x06B and 0x06C-0x06F select bit 10 (MMU set). All other types select bit 0 (alternate set). Other flag bits pass through unchanged.
- R8: Type 0x024 gives cwp-1. Types with (type & 0x1C0) = 0x080 give cwp-cansave-2. Types with (type & 0x1C0) = 0x0C0 give cwp+1. All other types keep cwp. All of this is modulo N_WIN.
- R9: upd_pc is formed from cur_tbr_hi in bits 63:15, bit 14 = (new level > 1), the trap type in bits 13:5 and zero in bits 4:0. upd_npc = upd_pc + 4.
- R10: upd_valid is high for exactly the cycle after each accepted strobe edge and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Single-cycle trap strobe |
| trap_type | input | 9 | Trap type code |
| cur_tl | input | TL_W | Current trap level |
| cur_pstate | input | 12 | Current state flags |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Free-save window count |
| cur_tbr_hi | input | PC_W-15 | Trap base register bits PC_W-1:15 |
| cur_pc | input | PC_W | PC at the trap |
| cur_npc | input | PC_W | NPC at the trap |
| rd_level | input | TL_W | Trap stack read index |
| upd_valid | output | 1 | Updated registers valid |
| upd_tl | output | TL_W | New trap level |
| upd_pstate | output | 12 | New state flags |
| upd_cwp | output | CWP_W | New window pointer |
| upd_pc | output | PC_W | Handler PC |
| upd_npc | output | PC_W | Handler NPC |
| error_state | output | 1 | Sticky error state |
| rd_tstate | output | 40 | Stack entry saved state word |
| rd_tpc | output | PC_W | Stack entry PC |
| rd_tnpc | output | PC_W | Stack entry NPC |
| rd_tt | output | 9 | Stack entry trap type |

## Verification
The hardest case to reach is the step into the error state. Only a trap arriving exactly at the limit level gets there, and it must leave both the outputs and the stack slot written by the previous trap untouched. The stimulus issues back-to-back strobes that climb the level from 0 to the limit, one level per cycle, and then fires one more trap with a different PC. It then reads that slot back through the read port. The window wraparound below zero is reached by clean-window and spill traps taken at small window pointers.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam int PS_W = 12;
   localparam int TT_W = 9;
   localparam int SAVED_W = 40;

   localparam int PS_ALT_G  = 0;
   localparam int PS_PRIV   = 2;
   localparam int PS_FPEN   = 4;
   localparam int PS_RSTERR = 5;
   localparam int PS_MMU_G  = 10;
   localparam int PS_INT_G  = 11;

   localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;
   localparam logic [PS_W-1:0] PS_GSET_MASK = 12'hC01;

   localparam logic [TT_W-1:0] TT_INT_VEC   = 9'h060;
   localparam logic [TT_W-1:0] TT_I_FAULT   = 9'h008;
   localparam logic [TT_W-1:0] TT_D_FAULT   = 9'h030;
   localparam logic [TT_W-1:0] TT_I_MISS    = 9'h064;
   localparam logic [TT_W-1:0] TT_D_MISS    = 9'h068;
   localparam logic [TT_W-1:0] TT_D_PROT    = 9'h06C;
   localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
   localparam logic [TT_W-1:0] TT_CLASS_MSK = 9'h1C0;
   localparam logic [TT_W-1:0] TT_SPILL_B   = 9'h080;
   localparam logic [TT_W-1:0] TT_FILL_B    = 9'h0C0;

   typedef enum logic [1:0] {
      GSET_ALT = 2'd0,
      GSET_MMU = 2'd1,
      GSET_INT = 2'd2
   } gset_e;

   typedef enum logic [1:0] {
      WADJ_NONE  = 2'd0,
      WADJ_CLEAN = 2'd1,
      WADJ_SPILL = 2'd2,
      WADJ_FILL  = 2'd3
   } wadj_e;

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
   parameter int MAX_TL = 5,
   parameter int TL_W   = 3
) (
   input  logic [TL_W-1:0] cur_tl,
   output logic [TL_W-1:0] next_tl,
   output logic            set_rsterr,
   output logic            tl_over
);
   localparam logic [TL_W-1:0] TL_MAX_V = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] TL_SAT_V = TL_W'(MAX_TL - 1);

   always_comb begin
      tl_over = (cur_tl >= TL_MAX_V);
      if (cur_tl < TL_SAT_V) begin
         set_rsterr = 1'b0;
         next_tl    = cur_tl + TL_W'(1);
      end else begin
         set_rsterr = 1'b1;
         next_tl    = (cur_tl < TL_MAX_V) ? cur_tl + TL_W'(1) : cur_tl;
      end
   end
endmodule

// File: rtl/trap_class_decode.sv
module trap_class_decode
   import trap_entry_pkg::*;
(
   input  logic [TT_W-1:0] tt,
   output gset_e           gset,
   output wadj_e           wadj
);
   logic mmu_hit;

   always_comb begin
      mmu_hit = (tt == TT_I_FAULT) || (tt == TT_D_FAULT)
             || (tt[TT_W-1:2] == TT_I_MISS[TT_W-1:2])
             || (tt[TT_W-1:2] == TT_D_MISS[TT_W-1:2])
             || (tt[TT_W-1:2] == TT_D_PROT[TT_W-1:2]);
      if (tt == TT_INT_VEC)  gset = GSET_INT;
      else if (mmu_hit)      gset = GSET_MMU;
      else                   gset = GSET_ALT;

      if (tt == TT_CLEAN_WIN)                      wadj = WADJ_CLEAN;
      else if ((tt & TT_CLASS_MSK) == TT_SPILL_B)  wadj = WADJ_SPILL;
      else if ((tt & TT_CLASS_MSK) == TT_FILL_B)   wadj = WADJ_FILL;
      else                                         wadj = WADJ_NONE;
   end
endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj
   import trap_entry_pkg::*;
#(
   parameter int N_WIN = 8,
   parameter int CWP_W = 3
) (
   input  logic [CWP_W-1:0] cwp,
   input  logic [CWP_W-1:0] cansave,
   input  wadj_e            wadj,
   output logic [CWP_W-1:0] new_cwp
);
   localparam int  EXT_W   = CWP_W + 2;
   localparam bit  IS_POW2 = ((N_WIN & (N_WIN - 1)) == 0);

   generate
      if (IS_POW2) begin : g_pow2
         always_comb begin
            case (wadj)
               WADJ_CLEAN: new_cwp = cwp - CWP_W'(1);
               WADJ_SPILL: new_cwp = cwp - cansave - CWP_W'(2);
               WADJ_FILL:  new_cwp = cwp + CWP_W'(1);
               default:    new_cwp = cwp;
            endcase
         end
      end else begin : g_modulo
         logic [EXT_W-1:0] ext;
         logic [EXT_W-1:0] wrapped;
         always_comb begin
            case (wadj)
               WADJ_CLEAN: ext = {2'b00, cwp} + EXT_W'(N_WIN - 1);
               WADJ_SPILL: ext = {2'b00, cwp} + EXT_W'(2 * N_WIN - 2)
                                 - {2'b00, cansave};
               WADJ_FILL:  ext = {2'b00, cwp} + EXT_W'(1);
               default:    ext = {2'b00, cwp};
            endcase
            wrapped = ext % EXT_W'(N_WIN);
            new_cwp = wrapped[CWP_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
   import trap_entry_pkg::*;
#(
   parameter int PC_W = 64,
   parameter int TL_W = 3
) (
   input  logic [PC_W-16:0] tbr_hi,
   input  logic [TL_W-1:0]  new_tl,
   input  logic [TT_W-1:0]  tt,
   output logic [PC_W-1:0]  vec_pc,
   output logic [PC_W-1:0]  vec_npc
);
   logic nested;

   always_comb begin
      nested  = (new_tl > TL_W'(1));
      vec_pc  = {tbr_hi, nested, tt, 5'b00000};
      vec_npc = vec_pc + PC_W'(4);
   end
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
   parameter int AW    = 3,
   parameter int EW    = 177,
   parameter bit CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] widx,
   input  logic [EW-1:0] wdata,
   input  logic [AW-1:0] ridx,
   output logic [EW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [EW-1:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[widx] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[ridx];

   // R6: an accepted trap always lands above level zero
   p_stack_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (widx != '0));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int MAX_TL      = 5,
   parameter int N_WIN       = 8,
   parameter int PC_W        = 64,
   parameter bit STACK_CLEAR = 1'b1,
   localparam int TL_W  = $clog2(MAX_TL + 1),
   localparam int CWP_W = $clog2(N_WIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_req,
   input  logic [TT_W-1:0]  trap_type,
   input  logic [TL_W-1:0]  cur_tl,
   input  logic [PS_W-1:0]  cur_pstate,
   input  logic [7:0]       cur_ccr,
   input  logic [7:0]       cur_asi,
   input  logic [CWP_W-1:0] cur_cwp,
   input  logic [CWP_W-1:0] cur_cansave,
   input  logic [PC_W-16:0] cur_tbr_hi,
   input  logic [PC_W-1:0]  cur_pc,
   input  logic [PC_W-1:0]  cur_npc,
   input  logic [TL_W-1:0]  rd_level,
   output logic             upd_valid,
   output logic [TL_W-1:0]  upd_tl,
   output logic [PS_W-1:0]  upd_pstate,
   output logic [CWP_W-1:0] upd_cwp,
   output logic [PC_W-1:0]  upd_pc,
   output logic [PC_W-1:0]  upd_npc,
   output logic             error_state,
   output logic [SAVED_W-1:0] rd_tstate,
   output logic [PC_W-1:0]  rd_tpc,
   output logic [PC_W-1:0]  rd_tnpc,
   output logic [TT_W-1:0]  rd_tt
);
   localparam int ENTRY_W = SAVED_W + 2 * PC_W + TT_W;
   localparam logic [TL_W-1:0] TL_MAX_V = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] TL_SAT_V = TL_W'(MAX_TL - 1);

   initial begin
      if (MAX_TL < 2)    $fatal(1, "MAX_TL must be at least 2");
      if (N_WIN < 2)     $fatal(1, "N_WIN must be at least 2");
      if (CWP_W > 7)     $fatal(1, "N_WIN too large for the saved word");
      if (PC_W < 16)     $fatal(1, "PC_W must be at least 16");
   end

   logic [TL_W-1:0]   nxt_tl;
   logic              set_rsterr, tl_over, accept;
   gset_e             gset;
   wadj_e             wadj;
   logic [CWP_W-1:0]  nxt_cwp;
   logic [PC_W-1:0]   vec_pc, vec_npc;
   logic [PS_W-1:0]   ps_marked, gbit, nxt_ps;
   logic [SAVED_W-1:0] saved_word;
   logic [ENTRY_W-1:0] wr_entry, rd_entry;

   trap_level_ctl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_level (
      .cur_tl     (cur_tl),
      .next_tl    (nxt_tl),
      .set_rsterr (set_rsterr),
      .tl_over    (tl_over)
   );

   trap_class_decode u_class (
      .tt   (trap_type),
      .gset (gset),
      .wadj (wadj)
   );

   trap_window_adj #(.N_WIN(N_WIN), .CWP_W(CWP_W)) u_window (
      .cwp     (cur_cwp),
      .cansave (cur_cansave),
      .wadj    (wadj),
      .new_cwp (nxt_cwp)
   );

   trap_vector_gen #(.PC_W(PC_W), .TL_W(TL_W)) u_vector (
      .tbr_hi  (cur_tbr_hi),
      .new_tl  (nxt_tl),
      .tt      (trap_type),
      .vec_pc  (vec_pc),
      .vec_npc (vec_npc)
   );

   always_comb begin
      accept    = trap_req && !tl_over;
      ps_marked = cur_pstate;
      if (set_rsterr) ps_marked[PS_RSTERR] = 1'b1;
      gbit = '0;
      case (gset)
         GSET_INT: gbit[PS_INT_G] = 1'b1;
         GSET_MMU: gbit[PS_MMU_G] = 1'b1;
         default:  gbit[PS_ALT_G] = 1'b1;
      endcase
      nxt_ps = (ps_marked & ~PS_GSET_MASK) | gbit;
      nxt_ps[PS_FPEN] = 1'b1;
      nxt_ps[PS_PRIV] = 1'b1;
      saved_word = {cur_ccr, cur_asi, 4'b0000, ps_marked & PS_SAVE_MASK,
                    {(8 - CWP_W){1'b0}}, cur_cwp};
      wr_entry = {saved_word, cur_pc, cur_npc, trap_type};
   end

   trap_stack #(.AW(TL_W), .EW(ENTRY_W), .CLEAR(STACK_CLEAR)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accept),
      .widx  (nxt_tl),
      .wdata (wr_entry),
      .ridx  (rd_level),
      .rdata (rd_entry)
   );

   assign {rd_tstate, rd_tpc, rd_tnpc, rd_tt} = rd_entry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_valid   <= 1'b0;
         upd_tl      <= '0;
         upd_pstate  <= '0;
         upd_cwp     <= '0;
         upd_pc      <= '0;
         upd_npc     <= '0;
         error_state <= 1'b0;
      end else begin
         upd_valid <= accept;
         if (accept) begin
            upd_tl     <= nxt_tl;
            upd_pstate <= nxt_ps;
            upd_cwp    <= nxt_cwp;
            upd_pc     <= vec_pc;
            upd_npc    <= vec_npc;
         end
         if (trap_req && tl_over) error_state <= 1'b1;
      end
   end

   p_tl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && cur_tl < TL_SAT_V) |=> (upd_tl == $past(cur_tl) + TL_W'(1)));

   p_sat_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && cur_tl == TL_SAT_V) |=> (upd_pstate[PS_RSTERR] && upd_tl == TL_MAX_V));

   p_err_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && cur_tl >= TL_MAX_V) |=> (!upd_valid && error_state));

   p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_pstate[PS_FPEN] && upd_pstate[PS_PRIV]
                     && $countones({upd_pstate[PS_INT_G], upd_pstate[PS_MMU_G],
                                    upd_pstate[PS_ALT_G]}) == 1));

   p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_pc[4:0] == 5'b00000 && upd_pc[13:5] == $past(trap_type)
                     && upd_pc[14] == (upd_tl > TL_W'(1))));

   p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $past(trap_req));
endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic [8:0]  trap_type = '0;
   logic [2:0]  cur_tl = '0;
   logic [11:0] cur_pstate = '0;
   logic [7:0]  cur_ccr = '0, cur_asi = '0;
   logic [2:0]  cur_cwp = '0, cur_cansave = '0;
   logic [48:0] cur_tbr_hi = 49'h1_2345_6789_ABCD;
   logic [63:0] cur_pc = '0, cur_npc = '0;
   logic [2:0]  rd_level = '0;
   logic        upd_valid, error_state;
   logic [2:0]  upd_tl, upd_cwp;
   logic [11:0] upd_pstate;
   logic [63:0] upd_pc, upd_npc, rd_tpc, rd_tnpc;
   logic [39:0] rd_tstate;
   logic [8:0]  rd_tt;

   always #10 clk = ~clk;

   trap_entry_unit uut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
      .cur_tl(cur_tl), .cur_pstate(cur_pstate), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
      .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_tbr_hi(cur_tbr_hi),
      .cur_pc(cur_pc), .cur_npc(cur_npc), .rd_level(rd_level),
      .upd_valid(upd_valid), .upd_tl(upd_tl), .upd_pstate(upd_pstate),
      .upd_cwp(upd_cwp), .upd_pc(upd_pc), .upd_npc(upd_npc),
      .error_state(error_state), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc),
      .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
   );

   typedef struct {
      logic [2:0]  tl;
      logic [11:0] ps;
      logic [2:0]  cwp;
      logic [63:0] pc;
      logic [63:0] npc;
      bit          sat;
   } exp_t;

   exp_t        sb[$];
   logic [176:0] exp_stack [8];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent reference model of one trap entry
   task automatic model(input [8:0] tt, input [2:0] tl, input [11:0] ps,
                        input [2:0] cwp, input [2:0] cs, output exp_t e,
                        output [39:0] saved);
      logic [11:0] p;
      logic [11:0] sel;
      p = ps;
      e.sat = (tl >= 3'd4);
      if (e.sat) p[5] = 1'b1;
      e.tl = tl + 3'd1;
      saved = {cur_ccr, cur_asi, 4'h0, p & 12'hF3F, 5'b0, cwp};
      if (tt == 9'h060) sel = 12'h800;
      else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F))
         sel = 12'h400;
      else sel = 12'h001;
      e.ps = (p & ~12'hC01) | sel | 12'h014;
      if (tt == 9'h024)                 e.cwp = cwp - 3'd1;
      else if (tt >= 9'h080 && tt <= 9'h0BF) e.cwp = cwp - cs - 3'd2;
      else if (tt >= 9'h0C0 && tt <= 9'h0FF) e.cwp = cwp + 3'd1;
      else                              e.cwp = cwp;
      e.pc  = {cur_tbr_hi, (e.tl > 3'd1), tt, 5'b0};
      e.npc = e.pc + 64'd4;
   endtask

   // driver: call at a falling edge; leaves the strobe high for one cycle
   task automatic issue(input [8:0] tt, input [2:0] tl, input [11:0] ps,
                        input [2:0] cwp, input [2:0] cs, input [63:0] pc);
      exp_t e;
      logic [39:0] saved;
      trap_type = tt; cur_tl = tl; cur_pstate = ps; cur_cwp = cwp;
      cur_cansave = cs; cur_pc = pc; cur_npc = pc + 64'd4;
      cur_ccr = pc[15:8]; cur_asi = pc[7:0] ^ 8'h5A;
      model(tt, tl, ps, cwp, cs, e, saved);
      sb.push_back(e);
      exp_stack[e.tl] = {saved, pc, pc + 64'd4, tt};
      trap_req = 1'b1;
      @(negedge clk);
   endtask

   task automatic stack_chk(input [2:0] lvl);
      rd_level = lvl;
      #1;
      chk(rd_tstate == exp_stack[lvl][176:137], "R5 saved word",
          {24'h0, rd_tstate}, {24'h0, exp_stack[lvl][176:137]});
      chk(rd_tpc == exp_stack[lvl][136:73], "R6 stack pc", rd_tpc, exp_stack[lvl][136:73]);
      chk(rd_tnpc == exp_stack[lvl][72:9], "R6 stack npc", rd_tnpc, exp_stack[lvl][72:9]);
      chk(rd_tt == exp_stack[lvl][8:0], "R6 stack tt", {55'h0, rd_tt},
          {55'h0, exp_stack[lvl][8:0]});
   endtask

   // monitor: compares produced results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && upd_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10 valid without trap", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(upd_tl == e.tl, e.sat ? "R3 level" : "R2 level", {61'h0, upd_tl}, {61'h0, e.tl});
            chk(upd_pstate == e.ps, e.sat ? "R3/R7 flags" : "R7 flags",
                {52'h0, upd_pstate}, {52'h0, e.ps});
            chk(upd_cwp == e.cwp, "R8 window", {61'h0, upd_cwp}, {61'h0, e.cwp});
            chk(upd_pc == e.pc, "R9 pc", upd_pc, e.pc);
            chk(upd_npc == e.npc, "R9 npc", upd_npc, e.npc);
         end
      end
   end

   logic [8:0] sw_tt  [16] = '{9'h060, 9'h008, 9'h030, 9'h064, 9'h067, 9'h068,
                               9'h06B, 9'h06C, 9'h06F, 9'h070, 9'h024, 9'h080,
                               9'h0BF, 9'h0C0, 9'h0FF, 9'h17F};
   logic [2:0] sw_cwp [16] = '{3'd3, 3'd4, 3'd5, 3'd6, 3'd0, 3'd1, 3'd2, 3'd3,
                               3'd4, 3'd5, 3'd0, 3'd1, 3'd6, 3'd7, 3'd2, 3'd5};
   logic [2:0] sw_cs  [16] = '{3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2,
                               3'd2, 3'd2, 3'd2, 3'd3, 3'd0, 3'd2, 3'd2, 3'd1};

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(upd_valid == 1'b0 && error_state == 1'b0, "R1 reset flags",
          {62'h0, upd_valid, error_state}, 64'h0);
      chk(upd_tl == 3'd0, "R1 reset level", {61'h0, upd_tl}, 64'h0);
      rd_level = 3'd3; #1;
      chk(rd_tstate == '0 && rd_tt == '0, "R1 reset stack", {24'h0, rd_tstate}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3: back-to-back climb to the limit
      issue(9'h060, 3'd0, 12'h0C2, 3'd2, 3'd1, 64'h0000_4000_0000_1000);
      issue(9'h008, 3'd1, 12'hAC2, 3'd5, 3'd1, 64'h0000_4000_0000_2004);
      issue(9'h041, 3'd2, 12'h3FE, 3'd0, 3'd1, 64'h0000_4000_0000_3008);
      issue(9'h065, 3'd3, 12'h801, 3'd7, 3'd1, 64'h0000_4000_0000_400C);
      issue(9'h0C3, 3'd4, 12'h102, 3'd7, 3'd1, 64'h0000_4000_0000_5010);
      trap_req = 1'b0;
      @(negedge clk);
      chk(upd_valid == 1'b0, "R10 valid drops", {63'h0, upd_valid}, 64'h0);
      for (int l = 1; l <= 5; l++) stack_chk(3'(l));

      // R4: trap at the limit enters the error state
      trap_type = 9'h011; cur_tl = 3'd5; cur_pc = 64'hDEAD_0000_0000_0000;
      trap_req = 1'b1;
      @(negedge clk);
      trap_req = 1'b0;
      chk(upd_valid == 1'b0, "R4 no update", {63'h0, upd_valid}, 64'h0);
      chk(error_state == 1'b1, "R4 error state", {63'h0, error_state}, 64'h1);
      rd_level = 3'd5; #1;
      chk(rd_tpc == exp_stack[5][136:73], "R4 stack kept", rd_tpc, exp_stack[5][136:73]);
      @(negedge clk);
      chk(error_state == 1'b1, "R4 sticky", {63'h0, error_state}, 64'h1);

      // R1: reset clears the error state
      rst_n = 1'b0;
      @(negedge clk);
      chk(error_state == 1'b0, "R1 error cleared", {63'h0, error_state}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7/R8/R9: class sweep, alternating nesting depth
      for (int i = 0; i < 16; i++)
         issue(sw_tt[i], 3'(i % 2), 12'hAC2 ^ 12'(i), sw_cwp[i], sw_cs[i],
               64'h0000_0100_0000_0000 + 64'(i * 16));
      trap_req = 1'b0;
      @(negedge clk);
      stack_chk(3'd1);
      stack_chk(3'd2);
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R10 all results produced", 64'(sb.size()), 64'h0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=0 expected=1");
         summary();
         $finish;
      end
   end
endmodule